// File: doc/BRIEF.md
# Protected-Mode Segment Selector Translator

This block turns a segment selector and a 16-bit offset into a 24-bit physical address. The selector is not a paragraph address. It names an entry in one of two descriptor tables, one global and one local. A segment load supplies a selector for one of the segment slots. The block then reads the 8-byte descriptor from memory as four 16-bit words, one word per cycle, on a synchronous read port. It checks the table bound, the privilege and the present bit, and on success stores the descriptor in that slot's cache entry.

Each later access names a slot and an offset. One cycle later the block returns the base plus the offset, or it returns a protection fault if the slot holds nothing usable or if the offset lies past the segment limit. Each table's base and limit sit in registers that a simple write port sets. The current privilege level is an input.

Fault codes on both result ports are: 0 = none, 1 = general protection, 2 = not present.

Top module: `seltrans_unit`

## Requirements
- R1: Selector bits 15..3 are the descriptor index, bit 2 selects the table (0 = global, 1 = local), and bits 1..0 are the requested privilege level. The descriptor address is the selected table base plus index × 8.
- R2: A non-null load whose entry fits the table issues exactly four reads on consecutive cycles at the descriptor address plus 0, 2, 4 and 6. Read data is taken from the cycle after each request. Word 0 is the limit and word 1 is base[15:0]. Word 2 holds base[23:16] in bits 7..0, the present bit in bit 15 and the descriptor privilege level in bits 14..13.
- R3: If index × 8 + 7 exceeds the selected table limit, the load finishes with code 1 and issues no read. An entry whose last byte equals the limit loads normally.
- R4: A null selector (index 0 with bit 2 at 0, any requested level) loads with code 0 and no read. A later access through that slot returns code 1. A selector with index 0 and bit 2 at 1 is not null.
- R5: A load returns code 1 when the larger of the current privilege level and the requested privilege level is numerically greater than the descriptor privilege level.
- R6: A load whose descriptor has the present bit at 0 returns code 2, unless R5 already gives code 1, which takes precedence.
- R7: A load that returns a nonzero code leaves the slot's previously cached descriptor in use.
- R8: An access result appears in the cycle after the request, with the address equal to base + offset modulo 2^24.
- R9: An access whose offset is greater than the cached limit returns code 1. An offset equal to the limit is translated.
- R10: An access through a slot not loaded since reset returns code 1.
- R11: ld_busy is high from the cycle after a fetching load is accepted until its result. ld_done marks the result for one cycle. A load request while busy is ignored.
- R12: A table write with tbl_wr_local at 0 sets the global base and limit, and with it at 1 sets the local ones. Later loads use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Write the table registers |
| tbl_wr_local | input | 1 | 0 = global table, 1 = local table |
| tbl_wr_base | input | 24 | Table base to write |
| tbl_wr_limit | input | 16 | Table limit to write |
| cpl | input | 2 | Current privilege level |
| ld_valid | input | 1 | Segment load request |
| ld_seg | input | 2 | Slot to load |
| ld_selector | input | 16 | Selector to load |
| ld_busy | output | 1 | Descriptor fetch in progress |
| ld_done | output | 1 | Load result valid |
| ld_fault | output | 2 | Load fault code |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 24 | Memory byte address of the read word |
| mem_rdata | input | 16 | Read data, one cycle after the request |
| acc_valid | input | 1 | Access request |
| acc_seg | input | 2 | Slot used by the access |
| acc_offset | input | 16 | Offset within the segment |
| acc_done | output | 1 | Access result valid |
| acc_addr | output | 24 | Physical address (0 on a fault) |
| acc_fault | output | 2 | Access fault code |

## Verification
Some properties are checked by the assertions on every cycle:
- read requests that follow one another advance by two bytes;
- null and out-of-table loads end without a fetch;
- the busy flag always drops together with a result;
- an access answers exactly one cycle after its request;
- an access reported clean never had an offset above its limit, and an access through an unusable slot always faults.

Other behaviour only the bench scenarios can show:
- the descriptor address for each table;
- the privilege and present decisions and their precedence;
- wrap-around of the physical address;
- that a faulted load keeps the old descriptor;
- that a request during a fetch is dropped;
- that table writes take effect.

// File: rtl/seltrans_pkg.sv
package seltrans_pkg;
  localparam int PA_W    = 24;
  localparam int OFF_W   = 16;
  localparam int SEL_W   = 16;
  localparam int IDX_W   = SEL_W - 3;
  localparam int PL_W    = 2;
  localparam int WORD_W  = 16;
  localparam int NWORDS  = 4;
  localparam int TOP_W   = IDX_W + 3;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_NP   = 2'd2
  } fault_e;

  typedef struct packed {
    logic             vld;
    logic             nul;
    logic [PA_W-1:0]  base;
    logic [OFF_W-1:0] lim;
  } seg_desc_t;

  function automatic logic [PA_W-1:0] desc_addr_f(logic [PA_W-1:0] tbase,
                                                  logic [IDX_W-1:0] idx);
    return tbase + PA_W'({idx, 3'b000});
  endfunction

  function automatic logic tab_over_f(logic [IDX_W-1:0] idx, logic [OFF_W-1:0] tlim);
    logic [TOP_W-1:0] last;
    last = {idx, 3'b111};
    return last > TOP_W'(tlim);
  endfunction

  function automatic logic priv_fail_f(logic [PL_W-1:0] cur, logic [PL_W-1:0] req,
                                       logic [PL_W-1:0] dpl);
    logic [PL_W-1:0] eff;
    eff = (cur > req) ? cur : req;
    return eff > dpl;
  endfunction

  function automatic logic [PA_W-1:0] phys_f(logic [PA_W-1:0] base, logic [OFF_W-1:0] off);
    return base + PA_W'(off);
  endfunction

  function automatic logic off_over_f(logic [OFF_W-1:0] off, logic [OFF_W-1:0] lim);
    return off > lim;
  endfunction
endpackage

// File: rtl/seltrans_tables.sv
module seltrans_tables
  import seltrans_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_local,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [OFF_W-1:0] wr_limit,
  output logic [PA_W-1:0]  gbase,
  output logic [OFF_W-1:0] glim,
  output logic [PA_W-1:0]  lbase,
  output logic [OFF_W-1:0] llim
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gbase <= '0;
      glim  <= '0;
      lbase <= '0;
      llim  <= '0;
    end else if (wr_en) begin
      if (wr_local) begin
        lbase <= wr_base;
        llim  <= wr_limit;
      end else begin
        gbase <= wr_base;
        glim  <= wr_limit;
      end
    end
  end
endmodule

// File: rtl/seltrans_fetch.sv
module seltrans_fetch
  import seltrans_pkg::*;
#(
  parameter int SEG_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [SEG_W-1:0]  ld_seg,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [PL_W-1:0]   cpl,
  input  logic [PA_W-1:0]   gbase,
  input  logic [OFF_W-1:0]  glim,
  input  logic [PA_W-1:0]   lbase,
  input  logic [OFF_W-1:0]  llim,
  output logic              mem_rd_en,
  output logic [PA_W-1:0]   mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output fault_e            code,
  output logic              commit,
  output logic [SEG_W-1:0]  commit_seg,
  output seg_desc_t         commit_desc
);
  localparam int CNT_W = $clog2(NWORDS);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_CHECK} st_e;

  st_e              state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rd_idx_q;
  logic             rd_pend_q;
  logic [PA_W-1:0]  daddr_q;
  logic [PL_W-1:0]  rpl_q;
  logic [SEG_W-1:0] seg_q;
  logic [WORD_W-1:0] w0_q, w1_q, w2_q;
  logic             done_q, commit_q, null_q;
  fault_e           code_q;

  // Selector decode
  logic [IDX_W-1:0] sel_idx;
  logic             sel_ti;
  logic             sel_null;
  logic [PA_W-1:0]  tab_base;
  logic [OFF_W-1:0] tab_lim;
  logic             tab_over;
  logic             ld_accept;

  assign sel_idx   = ld_sel[SEL_W-1:3];
  assign sel_ti    = ld_sel[2];
  assign sel_null  = (sel_idx == '0) && !sel_ti;
  assign tab_base  = sel_ti ? lbase : gbase;
  assign tab_lim   = sel_ti ? llim  : glim;
  assign tab_over  = tab_over_f(sel_idx, tab_lim);
  assign ld_accept = ld_valid && (state_q == S_IDLE);

  // Descriptor checks
  logic            chk_present;
  logic [PL_W-1:0] chk_dpl;
  logic            chk_priv_fail;
  fault_e          chk_code;
  logic            spare_unused;

  assign chk_present   = w2_q[15];
  assign chk_dpl       = w2_q[14:13];
  assign chk_priv_fail = priv_fail_f(cpl, rpl_q, chk_dpl);
  assign chk_code      = chk_priv_fail ? FLT_GP : (!chk_present ? FLT_NP : FLT_NONE);
  assign spare_unused  = ^w2_q[12:8];

  assign mem_rd_en = (state_q == S_FETCH);
  assign mem_addr  = daddr_q + PA_W'({cnt_q, 1'b0});
  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign code      = code_q;
  assign commit    = commit_q;
  assign commit_seg = seg_q;
  assign commit_desc = '{vld: 1'b1, nul: null_q, base: {w2_q[7:0], w1_q}, lim: w0_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      rd_idx_q  <= '0;
      rd_pend_q <= 1'b0;
      daddr_q   <= '0;
      rpl_q     <= '0;
      seg_q     <= '0;
      w0_q      <= '0;
      w1_q      <= '0;
      w2_q      <= '0;
      done_q    <= 1'b0;
      commit_q  <= 1'b0;
      null_q    <= 1'b0;
      code_q    <= FLT_NONE;
    end else begin
      done_q    <= 1'b0;
      commit_q  <= 1'b0;
      rd_pend_q <= mem_rd_en;
      rd_idx_q  <= cnt_q;
      if (rd_pend_q) begin
        case (rd_idx_q)
          CNT_W'(0): w0_q <= mem_rdata;
          CNT_W'(1): w1_q <= mem_rdata;
          CNT_W'(2): w2_q <= mem_rdata;
          default: ;
        endcase
      end
      case (state_q)
        S_IDLE: begin
          if (ld_accept) begin
            seg_q <= ld_seg;
            rpl_q <= ld_sel[1:0];
            if (sel_null) begin
              done_q   <= 1'b1;
              commit_q <= 1'b1;
              null_q   <= 1'b1;
              code_q   <= FLT_NONE;
            end else if (tab_over) begin
              done_q <= 1'b1;
              code_q <= FLT_GP;
            end else begin
              daddr_q <= desc_addr_f(tab_base, sel_idx);
              cnt_q   <= '0;
              state_q <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(NWORDS - 1)) state_q <= S_WAIT;
        end
        S_WAIT: state_q <= S_CHECK;
        S_CHECK: begin
          done_q   <= 1'b1;
          code_q   <= chk_code;
          commit_q <= (chk_code == FLT_NONE);
          null_q   <= 1'b0;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_RD_CONSECUTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && $past(mem_rd_en) |-> mem_addr == $past(mem_addr) + PA_W'(2)); // R2
  AST_NULL_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ld_accept && sel_null |=> !mem_rd_en && !busy && done); // R4
  AST_TABLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ld_accept && !sel_null && tab_over |=> !busy && done && code == FLT_GP); // R3
  AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R11
endmodule

// File: rtl/seltrans_segcache.sv
module seltrans_segcache
  import seltrans_pkg::*;
#(
  parameter int NSEG  = 4,
  parameter int SEG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [SEG_W-1:0] commit_seg,
  input  seg_desc_t        commit_desc,
  input  logic             acc_valid,
  input  logic [SEG_W-1:0] acc_seg,
  input  logic [OFF_W-1:0] acc_off,
  output logic             acc_done,
  output logic [PA_W-1:0]  acc_addr,
  output fault_e           acc_code
);
  seg_desc_t ent [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : gen_slot
    seg_desc_t slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q <= '0;
      else if (commit && (int'(commit_seg) == g)) slot_q <= commit_desc;
    end
    assign ent[g] = slot_q;
  end

  seg_desc_t cur;
  logic      unusable;
  logic      over;

  assign cur      = (int'(acc_seg) < NSEG) ? ent[acc_seg] : '0;
  assign unusable = !cur.vld || cur.nul;
  assign over     = off_over_f(acc_off, cur.lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_done <= 1'b0;
      acc_addr <= '0;
      acc_code <= FLT_NONE;
    end else begin
      acc_done <= acc_valid;
      if (acc_valid) begin
        if (unusable || over) begin
          acc_code <= FLT_GP;
          acc_addr <= '0;
        end else begin
          acc_code <= FLT_NONE;
          acc_addr <= phys_f(cur.base, acc_off);
        end
      end
    end
  end

  AST_ACC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> $past(acc_valid)); // R8
  AST_ACC_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done && acc_code == FLT_NONE |-> $past(acc_off) <= $past(cur.lim)); // R9
  AST_UNUSABLE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done && $past(unusable) |-> acc_code == FLT_GP); // R10
endmodule

// File: rtl/seltrans_unit.sv
module seltrans_unit
  import seltrans_pkg::*;
#(
  parameter int NSEG  = 4,
  parameter int SEG_W = $clog2(NSEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_wr_en,
  input  logic              tbl_wr_local,
  input  logic [PA_W-1:0]   tbl_wr_base,
  input  logic [OFF_W-1:0]  tbl_wr_limit,
  input  logic [PL_W-1:0]   cpl,
  input  logic              ld_valid,
  input  logic [SEG_W-1:0]  ld_seg,
  input  logic [SEL_W-1:0]  ld_selector,
  output logic              ld_busy,
  output logic              ld_done,
  output logic [1:0]        ld_fault,
  output logic              mem_rd_en,
  output logic [PA_W-1:0]   mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              acc_valid,
  input  logic [SEG_W-1:0]  acc_seg,
  input  logic [OFF_W-1:0]  acc_offset,
  output logic              acc_done,
  output logic [PA_W-1:0]   acc_addr,
  output logic [1:0]        acc_fault
);
  logic [PA_W-1:0]  gbase, lbase;
  logic [OFF_W-1:0] glim, llim;
  fault_e           ld_code, acc_code;
  logic             commit;
  logic [SEG_W-1:0] commit_seg;
  seg_desc_t        commit_desc;

  seltrans_tables u_tables (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_local(tbl_wr_local),
    .wr_base(tbl_wr_base), .wr_limit(tbl_wr_limit),
    .gbase(gbase), .glim(glim), .lbase(lbase), .llim(llim)
  );

  seltrans_fetch #(.SEG_W(SEG_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_seg(ld_seg),
    .ld_sel(ld_selector), .cpl(cpl),
    .gbase(gbase), .glim(glim), .lbase(lbase), .llim(llim),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(ld_busy), .done(ld_done), .code(ld_code),
    .commit(commit), .commit_seg(commit_seg), .commit_desc(commit_desc)
  );

  seltrans_segcache #(.NSEG(NSEG), .SEG_W(SEG_W)) u_cache (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_seg(commit_seg),
    .commit_desc(commit_desc), .acc_valid(acc_valid), .acc_seg(acc_seg),
    .acc_off(acc_offset), .acc_done(acc_done), .acc_addr(acc_addr),
    .acc_code(acc_code)
  );

  assign ld_fault  = ld_code;
  assign acc_fault = acc_code;
endmodule

// File: tb/seltrans_unit_tb.sv
module seltrans_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_wr_en = 1'b0, tbl_wr_local = 1'b0;
  logic [23:0] tbl_wr_base = '0;
  logic [15:0] tbl_wr_limit = '0;
  logic [1:0]  cpl = '0;
  logic        ld_valid = 1'b0;
  logic [1:0]  ld_seg = '0;
  logic [15:0] ld_selector = '0;
  logic        ld_busy, ld_done;
  logic [1:0]  ld_fault;
  logic        mem_rd_en;
  logic [23:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_seg = '0;
  logic [15:0] acc_offset = '0;
  logic        acc_done;
  logic [23:0] acc_addr;
  logic [1:0]  acc_fault;

  int checks = 0, failures = 0;
  logic [15:0] mem [0:1023];
  int          rd_cnt = 0;
  bit          rd_gap = 0;
  logic [23:0] rd_first = '0, rd_last = '0;

  localparam logic [23:0] GB = 24'h000200, LB = 24'h000600;

  seltrans_unit u_dut (.*);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= mem[mem_addr[10:1]];
      if (rd_cnt == 0) rd_first = mem_addr;
      else if (mem_addr != rd_last + 24'd2) rd_gap = 1;
      rd_last = mem_addr;
      rd_cnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic put_desc(bit local_t, int idx, logic [23:0] base, logic [15:0] lim, logic [7:0] acc);
    int w;
    w = int'(((local_t ? LB : GB) + 24'(idx * 8)) >> 1);
    mem[w]     = lim;
    mem[w + 1] = base[15:0];
    mem[w + 2] = {acc, base[23:16]};
    mem[w + 3] = 16'h0;
  endtask

  task automatic set_tab(bit local_t, logic [23:0] base, logic [15:0] lim);
    @(negedge clk);
    tbl_wr_en = 1; tbl_wr_local = local_t; tbl_wr_base = base; tbl_wr_limit = lim;
    @(negedge clk);
    tbl_wr_en = 0;
  endtask

  task automatic do_load(logic [1:0] seg, logic [15:0] sel, output logic [1:0] code);
    int n = 0;
    rd_cnt = 0; rd_gap = 0;
    @(negedge clk);
    ld_valid = 1; ld_seg = seg; ld_selector = sel;
    @(negedge clk);
    ld_valid = 0;
    while (!ld_done && n < 40) begin
      @(negedge clk);
      n++;
    end
    code = ld_fault;
    chk(ld_done == 1'b1, "R11", "load completes", 32'(ld_done), 1);
  endtask

  task automatic do_acc(logic [1:0] seg, logic [15:0] off, output logic [23:0] addr,
                        output logic [1:0] code);
    @(negedge clk);
    acc_valid = 1; acc_seg = seg; acc_offset = off;
    @(negedge clk);
    acc_valid = 0;
    chk(acc_done == 1'b1, "R8", "access result next cycle", 32'(acc_done), 1);
    addr = acc_addr; code = acc_fault;
  endtask

  task automatic t_reset;
    logic [23:0] a; logic [1:0] c;
    chk(!ld_busy && !ld_done && !mem_rd_en && !acc_done, "R11", "idle after reset",
        {ld_busy, ld_done, mem_rd_en, acc_done}, 0);
    do_acc(2'd0, 16'h0000, a, c);
    chk(c == 2'd1, "R10", "unloaded slot faults", c, 1);
  endtask

  task automatic t_global_load;
    logic [23:0] a; logic [1:0] c;
    do_load(2'd0, 16'h0018, c);
    chk(c == 2'd0, "R2", "global load code", c, 0);
    chk(rd_cnt == 4 && !rd_gap, "R2", "four consecutive reads", rd_cnt, 4);
    chk(rd_first == GB + 24'h18, "R1", "global descriptor address", rd_first, GB + 24'h18);
    @(negedge clk);
    chk(ld_done == 1'b0, "R11", "done lasts one cycle", 32'(ld_done), 0);
    do_acc(2'd0, 16'h0010, a, c);
    chk(c == 2'd0 && a == 24'h123410, "R8", "base plus offset", a, 24'h123410);
    do_acc(2'd0, 16'h0FFF, a, c);
    chk(c == 2'd0 && a == 24'h1243FF, "R9", "offset equal to limit", a, 24'h1243FF);
    do_acc(2'd0, 16'h1000, a, c);
    chk(c == 2'd1, "R9", "offset past limit", c, 1);
  endtask

  task automatic t_local_wrap;
    logic [23:0] a; logic [1:0] c;
    cpl = 2'd3;
    do_load(2'd1, 16'h0017, c);
    chk(c == 2'd0, "R1", "local load code", c, 0);
    chk(rd_first == LB + 24'h10, "R1", "local descriptor address", rd_first, LB + 24'h10);
    do_acc(2'd1, 16'h0200, a, c);
    chk(c == 2'd0 && a == 24'h000100, "R8", "address wraps modulo 2^24", a, 24'h000100);
    cpl = 2'd0;
    do_load(2'd2, 16'h0004, c);
    chk(c == 2'd0 && rd_cnt == 4, "R4", "index 0 local is not null", rd_cnt, 4);
    do_acc(2'd2, 16'h0005, a, c);
    chk(c == 2'd0 && a == 24'h0B0005, "R4", "local entry 0 translates", a, 24'h0B0005);
  endtask

  task automatic t_table_bound;
    logic [1:0] c;
    do_load(2'd3, 16'h0044, c);
    chk(c == 2'd1 && rd_cnt == 0, "R3", "local index past table", {c, 8'(rd_cnt)}, 16'h100);
    do_load(2'd3, 16'h0100, c);
    chk(c == 2'd1 && rd_cnt == 0, "R3", "global index past table", {c, 8'(rd_cnt)}, 16'h100);
    do_load(2'd3, 16'h00F8, c);
    chk(c == 2'd0 && rd_cnt == 4, "R3", "last entry in table loads", {c, 8'(rd_cnt)}, 16'h004);
  endtask

  task automatic t_privilege;
    logic [23:0] a; logic [1:0] c;
    cpl = 2'd3;
    do_load(2'd1, 16'h0028, c);
    chk(c == 2'd1, "R5", "current level above descriptor", c, 1);
    cpl = 2'd0;
    do_load(2'd1, 16'h002B, c);
    chk(c == 2'd1, "R5", "requested level above descriptor", c, 1);
    do_acc(2'd1, 16'h0200, a, c);
    chk(c == 2'd0 && a == 24'h000100, "R7", "faulted load keeps old slot", a, 24'h000100);
    cpl = 2'd2;
    do_load(2'd1, 16'h0029, c);
    chk(c == 2'd0, "R5", "levels within descriptor", c, 0);
    do_acc(2'd1, 16'h1000, a, c);
    chk(c == 2'd0 && a == 24'h051000, "R9", "new slot at its limit", a, 24'h051000);
    cpl = 2'd0;
  endtask

  task automatic t_present;
    logic [23:0] a; logic [1:0] c;
    do_load(2'd0, 16'h0033, c);
    chk(c == 2'd2, "R6", "not present descriptor", c, 2);
    cpl = 2'd3;
    do_load(2'd0, 16'h0038, c);
    chk(c == 2'd1, "R6", "privilege fault takes precedence", c, 1);
    cpl = 2'd0;
    do_acc(2'd0, 16'h0010, a, c);
    chk(c == 2'd0 && a == 24'h123410, "R7", "slot unchanged after not-present", a, 24'h123410);
  endtask

  task automatic t_null;
    logic [23:0] a; logic [1:0] c;
    do_load(2'd2, 16'h0003, c);
    chk(c == 2'd0 && rd_cnt == 0, "R4", "null load without reads", {c, 8'(rd_cnt)}, 0);
    do_acc(2'd2, 16'h0000, a, c);
    chk(c == 2'd1, "R4", "access through null slot", c, 1);
  endtask

  task automatic t_busy_ignore;
    logic [23:0] a; logic [1:0] c; int dones = 0;
    rd_cnt = 0; rd_gap = 0;
    @(negedge clk);
    ld_valid = 1; ld_seg = 2'd3; ld_selector = 16'h0048;
    @(negedge clk);
    chk(ld_busy == 1'b1, "R11", "busy after accept", 32'(ld_busy), 1);
    ld_selector = 16'h0000;
    @(negedge clk);
    ld_valid = 0;
    for (int i = 0; i < 20; i++) begin
      if (ld_done) dones++;
      @(negedge clk);
    end
    chk(dones == 1 && rd_cnt == 4, "R11", "request while busy dropped", dones, 1);
    do_acc(2'd3, 16'h0010, a, c);
    chk(c == 2'd0 && a == 24'h0A0010, "R11", "slot holds first load", a, 24'h0A0010);
  endtask

  task automatic t_table_write;
    logic [1:0] c;
    set_tab(1'b0, 24'h000300, 16'h00FF);
    do_load(2'd3, 16'h0018, c);
    chk(rd_first == 24'h000318, "R12", "new global base used", rd_first, 24'h000318);
    chk(c == 2'd2, "R12", "empty entry reads not present", c, 2);
    set_tab(1'b0, GB, 16'h00FF);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
    put_desc(1'b0, 3,  24'h123400, 16'h0FFF, 8'h92);
    put_desc(1'b1, 2,  24'hFFFF00, 16'hFFFF, 8'hF2);
    put_desc(1'b1, 0,  24'h0B0000, 16'h0020, 8'hF2);
    put_desc(1'b0, 31, 24'h040000, 16'h00FF, 8'h92);
    put_desc(1'b0, 5,  24'h050000, 16'h1000, 8'hD2);
    put_desc(1'b0, 6,  24'h060000, 16'h1000, 8'h72);
    put_desc(1'b0, 7,  24'h070000, 16'h1000, 8'h12);
    put_desc(1'b0, 9,  24'h0A0000, 16'h0010, 8'h92);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    set_tab(1'b0, GB, 16'h00FF);
    set_tab(1'b1, LB, 16'h003F);
    t_global_load;
    t_local_wrap;
    t_table_bound;
    t_privilege;
    t_present;
    t_null;
    t_busy_ignore;
    t_table_write;
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule